// File: doc/BRIEF.md
# Receive Data Holding and Status Flag Unit

This unit sits behind a serial receive shifter and holds the most recent received byte together with four status flags: receiver full, overrun, framing error and parity error. The shifter, which lies outside this unit, reports each finished frame with a single-cycle pulse. The pulse carries the byte, the sampled stop bit and a parity-fail indication. The unit derives an error interrupt from the framing and parity flags, each gated by its own enable. It also derives a receive interrupt from the full flag and its enable.

Software never writes the flags. A flag can only be cleared by a two-step read handshake on a simple read port, which has a strobe and an address. First, the status register is read. On that read, the unit records which flags are set at that moment. Later, the data register is read, and only the flags recorded earlier are cleared. Any flag that rises between the two reads stays set. If a new frame arrives before the handshake has emptied the holding register, the new byte is dropped and overrun is raised.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, the status register reads 0x00 and both interrupt outputs are low.
- R2: A frame pulse that arrives while receiver-full is clear loads the byte into the data register and sets receiver-full at the same clock edge. A data read at address 1 returns that byte.
- R3: An accepted frame whose stop bit is 0 sets the framing error flag. An accepted frame whose parity-fail input is 1 sets the parity error flag.
- R4: `err_irq` is high exactly when (framing error AND `fe_ie`) OR (parity error AND `pe_ie`).
- R5: `rx_irq` is high exactly when receiver-full AND `rx_ie`.
- R6: A frame pulse that arrives while receiver-full is set raises overrun and leaves the data register unchanged.
- R7: A status read at address 0 records the flags that are set at that moment. A later data read clears exactly those recorded flags and then discards the record.
- R8: A flag that rises after the status read and before the data read is not cleared by that data read.
- R9: A data read with no recorded flags returns the byte and clears nothing.
- R10: The status byte layout is: bit 5 receiver full, bit 3 overrun, bit 1 framing error, bit 0 parity error. All other bits read 0.
- R11: When every byte is followed by a status read and then a data read before the next frame pulse, every byte is returned in order and overrun stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle pulse marking a finished frame |
| frame_data | input | DATA_W | Received byte |
| frame_stop | input | 1 | Sampled stop bit |
| frame_perr | input | 1 | Parity check failed |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | 0 = status, 1 = data |
| rd_data | output | DATA_W | Combinational read data |
| fe_ie | input | 1 | Framing error interrupt enable |
| pe_ie | input | 1 | Parity error interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| err_irq | output | 1 | Error interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
`rd_data` is combinational, so it is valid in the same cycle as the read strobe. The bench drives the strobe at a falling edge and samples the data one time unit later, before the rising edge. A frame pulse or a read changes the flags at the next rising edge, and both interrupts follow those flags with no further delay. For that reason, every flag and interrupt check is made at the falling edge after the stimulus has been withdrawn, which is exactly one register stage later.

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_stop,
  input  logic              frame_perr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fe_ie,
  input  logic              pe_ie,
  input  logic              rx_ie,
  output logic              err_irq,
  output logic              rx_irq
);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DATA   = ADDR_W'(1);
  localparam int BIT_FULL = 5;
  localparam int BIT_OVR  = 3;
  localparam int BIT_FE   = 1;
  localparam int BIT_PE   = 0;

  logic [DATA_W-1:0] data_q;
  logic full_q, or_q, fe_q, pe_q;
  logic [3:0] arm_q;
  logic [3:0] clr;
  logic [DATA_W-1:0] status;

  wire accept = frame_valid & ~full_q;
  wire drop   = frame_valid &  full_q;
  wire st_rd  = rd_en & (rd_addr == ADDR_STATUS);
  wire dt_rd  = rd_en & (rd_addr == ADDR_DATA);

  assign clr = dt_rd ? arm_q : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      or_q   <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      arm_q  <= 4'b0000;
    end else begin
      if (accept) data_q <= frame_data;
      full_q <= (full_q & ~clr[3]) | accept;
      or_q   <= (or_q   & ~clr[2]) | drop;
      fe_q   <= (fe_q   & ~clr[1]) | (accept & ~frame_stop);
      pe_q   <= (pe_q   & ~clr[0]) | (accept & frame_perr);
      if (st_rd)      arm_q <= {full_q, or_q, fe_q, pe_q};
      else if (dt_rd) arm_q <= 4'b0000;
    end
  end

  always_comb begin
    status = '0;
    status[BIT_FULL] = full_q;
    status[BIT_OVR]  = or_q;
    status[BIT_FE]   = fe_q;
    status[BIT_PE]   = pe_q;
  end

  assign rd_data = st_rd ? status : (dt_rd ? data_q : '0);
  assign err_irq = (fe_q & fe_ie) | (pe_q & pe_ie);
  assign rx_irq  = full_q & rx_ie;
endmodule

module uart_rx_flags_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic [DATA_W-1:0] frame_data,
  input logic              frame_stop,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              err_irq,
  input logic [DATA_W-1:0] data_q,
  input logic              full_q,
  input logic              or_q,
  input logic              fe_q,
  input logic              pe_q,
  input logic [3:0]        arm_q
);
  wire data_rd = rd_en && (rd_addr == ADDR_W'(1));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !full_q) |=> (full_q && data_q == $past(frame_data)));

  assert_frame_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !full_q && !frame_stop) |=> fe_q);

  assert_err_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (fe_q || pe_q));

  assert_overrun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && full_q) |=> (or_q && $stable(data_q)));

  assert_late_survives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !arm_q[2] && or_q) |=> or_q);

  assert_unarmed_noclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && arm_q == 4'b0000 && !frame_valid) |=> $stable({full_q, or_q, fe_q, pe_q}));
endmodule

bind uart_rx_flags uart_rx_flags_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
  .frame_stop(frame_stop), .rd_en(rd_en), .rd_addr(rd_addr), .err_irq(err_irq),
  .data_q(data_q), .full_q(full_q), .or_q(or_q), .fe_q(fe_q), .pe_q(pe_q),
  .arm_q(arm_q)
);

// File: tb/uart_rx_flags_tb.sv
module uart_rx_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [7:0] frame_data = '0;
  logic frame_stop = 1'b1;
  logic frame_perr = 1'b0;
  logic rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic fe_ie = 1'b0, pe_ie = 1'b0, rx_ie = 1'b0;
  logic err_irq, rx_irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_flags u_dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_stop(frame_stop), .frame_perr(frame_perr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .fe_ie(fe_ie), .pe_ie(pe_ie), .rx_ie(rx_ie),
    .err_irq(err_irq), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic stop, input logic perr);
    @(negedge clk);
    frame_valid = 1'b1; frame_data = d; frame_stop = stop; frame_perr = perr;
    @(negedge clk);
    frame_valid = 1'b0; frame_stop = 1'b1; frame_perr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_seq;
    logic [7:0] v;
    rd(2'd0, v);
    rd(2'd1, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 irqs", {6'd0, err_irq, rx_irq}, 8'h00);
    rd(2'd0, v);
    check("R1 status", v, 8'h00);
  endtask

  task automatic t_single;
    logic [7:0] v;
    rx_ie = 1'b1;
    frame(8'hA5, 1'b1, 1'b0);
    check("R5 rx_irq set", {7'd0, rx_irq}, 8'h01);
    rd(2'd0, v);
    check("R10 status full", v, 8'h20);
    rd(2'd1, v);
    check("R2 data", v, 8'hA5);
    check("R7 rx_irq cleared", {7'd0, rx_irq}, 8'h00);
    rd(2'd0, v);
    check("R7 status clear", v, 8'h00);
    rx_ie = 1'b0;
  endtask

  task automatic t_errors;
    logic [7:0] v;
    frame(8'h3C, 1'b0, 1'b0);
    rd(2'd0, v);
    check("R3 framing", v, 8'h22);
    check("R4 no enable", {7'd0, err_irq}, 8'h00);
    fe_ie = 1'b1; #1;
    check("R4 fe enable", {7'd0, err_irq}, 8'h01);
    fe_ie = 1'b0; pe_ie = 1'b1; #1;
    check("R4 pe en only", {7'd0, err_irq}, 8'h00);
    rd(2'd1, v);
    rd(2'd0, v);
    check("R7 fe cleared", v, 8'h00);
    frame(8'h5A, 1'b1, 1'b1);
    rd(2'd0, v);
    check("R3 parity", v, 8'h21);
    check("R4 pe irq", {7'd0, err_irq}, 8'h01);
    rd(2'd1, v);
    check("R4 irq after clear", {7'd0, err_irq}, 8'h00);
    pe_ie = 1'b0;
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    frame(8'h11, 1'b1, 1'b0);
    frame(8'h22, 1'b1, 1'b0);
    rd(2'd0, v);
    check("R6 overrun", v, 8'h28);
    rd(2'd1, v);
    check("R6 data held", v, 8'h11);
    rd(2'd0, v);
    check("R7 both cleared", v, 8'h00);
  endtask

  task automatic t_late;
    logic [7:0] v;
    frame(8'h44, 1'b1, 1'b0);
    rd(2'd0, v);
    check("R7 armed full", v, 8'h20);
    frame(8'h55, 1'b1, 1'b0);
    rd(2'd1, v);
    check("R8 data", v, 8'h44);
    rd(2'd0, v);
    check("R8 overrun survives", v, 8'h08);
    rd(2'd1, v);
    rd(2'd0, v);
    check("R8 then cleared", v, 8'h00);
  endtask

  task automatic t_unarmed;
    logic [7:0] v;
    frame(8'h66, 1'b0, 1'b0);
    rd(2'd1, v);
    check("R9 data", v, 8'h66);
    rd(2'd0, v);
    check("R9 flags kept", v, 8'h22);
    rd(2'd1, v);
    rd(2'd0, v);
    check("R9 cleared later", v, 8'h00);
  endtask

  task automatic t_stream;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      frame(8'(8'h80 + i * 8'h13), 1'b1, 1'b0);
      rd(2'd0, v);
      check("R11 status", v, 8'h20);
      rd(2'd1, v);
      check("R11 byte", v, 8'(8'h80 + i * 8'h13));
    end
    rd(2'd0, v);
    check("R11 no overrun", v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_errors();
    t_overrun();
    t_late();
    t_unarmed();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule